// File: doc/BRIEF.md
# Port-Size Access Splitter

This block sits between a 32-bit internal requester and a bus-cycle engine that drives an external data port. The port is configured as either 32 bits wide or 8 bits wide. A request is either a full word or a single byte. A word sent to an 8-bit port becomes four byte beats. The beats go out either as stand-alone cycles or as one burst, and the choice is made separately for reads and for writes.

Each beat is placed on the correct lanes of the 32-bit external bus. An 8-bit device can be wired to the top lane or to the bottom lane, and a configuration bit says which. Read bytes are collected into a holding register, and the requester sees one response once the final beat is done. The configuration inputs are captured when a request is accepted, so a change made in the middle of a transfer has no effect on it.

Top module: `port_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and both `beat_valid` and `rsp_valid` are 0.
- R2: On a 32-bit port (`cfg_port_size` = 00), a word access is one beat with `beat_be` = 1111, `beat_burst` = 0 and `beat_last` = 1. This holds whatever the burst enables are. A write drives all 32 bits of `req_wdata`, and a read returns `beat_rdata` unchanged.
- R3: Port size codes 10 and 11 behave exactly like code 00.
- R4: On an 8-bit port (`cfg_port_size` = 01), `cfg_lane_low` = 0 places the byte on lines 31:24 with `beat_be` = 1000. `cfg_lane_low` = 1 places it on lines 7:0 with `beat_be` = 0001. All other lanes are driven to 0. Read bytes are taken from the same lane.
- R5: A word access to an 8-bit port issues four beats, most significant byte first. The address is the request address plus 0, 1, 2 and 3, wrapping modulo 2^AW.
- R6: Without the matching burst enable, each of those beats has `beat_burst` = 0 and `beat_last` = 1, and `beat_valid` is low for at least one cycle between beats.
- R7: With the matching burst enable, the four beats have `beat_burst` = 1 and run back to back. `beat_last` is 1 only on the fourth beat.
- R8: Writes follow only `cfg_burst_wr`, and reads follow only `cfg_burst_rd`.
- R9: `rsp_valid` pulses exactly once per request, in the cycle after the acknowledge of the final beat. For a word read from an 8-bit port, `rsp_rdata` holds the first beat's byte in bits 31:24 and the last beat's byte in bits 7:0. For writes, `rsp_rdata` is 0.
- R10: A byte access is always one non-burst beat. On a 32-bit port it uses lines 7:0 with `beat_be` = 0001. On an 8-bit port it uses the lane given by R4. A byte read returns the byte zero-extended in `rsp_rdata[7:0]`.
- R11: While a request is in progress, `req_ready` is 0. The beat outputs hold steady until `beat_ack`. Configuration changes made after acceptance do not affect that request. On reads, `beat_wdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_port_size | input | 2 | 00 = 32-bit port, 01 = 8-bit port, 10 and 11 are treated as 32-bit |
| cfg_lane_low | input | 1 | 8-bit port lane: 0 = lines 31:24, 1 = lines 7:0 |
| cfg_burst_rd | input | 1 | Run oversized reads as a burst |
| cfg_burst_wr | input | 1 | Run oversized writes as a burst |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data; a byte access uses bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| beat_valid | output | 1 | Beat presented to the cycle engine |
| beat_write | output | 1 | Beat direction |
| beat_addr | output | AW | Beat byte address |
| beat_wdata | output | 32 | Lane-steered write data |
| beat_be | output | 4 | Active byte lanes |
| beat_burst | output | 1 | Beat belongs to a burst sequence |
| beat_last | output | 1 | Final beat of its bus cycle or burst |
| beat_ack | input | 1 | Engine completes the presented beat |
| beat_rdata | input | 32 | Read data, valid with `beat_ack` |

## Verification
The bench builds the block with AW = 12. This lets a word access to an 8-bit port start at 0xFFE, so the per-beat address increment is checked as it wraps through the top of the address space.

The engine model returns a different value on each lane, and that value depends on the address. A wrong lane choice or a wrong byte order therefore shows up in the assembled word. The model also stalls its acknowledge on a fixed pattern, which exercises held beats and the gap between stand-alone cycles.

// File: rtl/port_splitter.sv
`timescale 1ns/1ps
module port_splitter #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_port_size,
  input  logic          cfg_lane_low,
  input  logic          cfg_burst_rd,
  input  logic          cfg_burst_wr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          beat_valid,
  output logic          beat_write,
  output logic [AW-1:0] beat_addr,
  output logic [31:0]   beat_wdata,
  output logic [3:0]    beat_be,
  output logic          beat_burst,
  output logic          beat_last,
  input  logic          beat_ack,
  input  logic [31:0]   beat_rdata
);
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int IW = $clog2(NB);
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

  logic          busy, gap, wr, word, narrow, low, burst;
  logic [IW-1:0] idx;
  logic [AW-1:0] base;
  logic [DW-1:0] wd;
  logic [DW-9:0] hold;

  logic          multi, is_last, done;
  logic [7:0]    out_byte, in_byte;
  logic [DW-1:0] steered, assembled;

  assign multi   = word && narrow;
  assign is_last = multi ? (idx == LAST_IDX) : 1'b1;
  assign done    = beat_valid && beat_ack;

  assign req_ready  = !busy;
  assign beat_valid = busy && !gap;
  assign beat_write = wr;
  assign beat_addr  = base + AW'(idx);
  assign beat_burst = burst;
  assign beat_last  = !burst || is_last;

  assign out_byte = word ? wd[(DW-1) - 8*idx -: 8] : wd[7:0];
  assign in_byte  = low ? beat_rdata[7:0] : beat_rdata[DW-1 -: 8];

  always_comb begin
    if (!narrow) begin
      steered = word ? wd : {{(DW-8){1'b0}}, wd[7:0]};
      beat_be = word ? '1 : 4'b0001;
    end else if (low) begin
      steered = {{(DW-8){1'b0}}, out_byte};
      beat_be = 4'b0001;
    end else begin
      steered = {out_byte, {(DW-8){1'b0}}};
      beat_be = 4'b1000;
    end
  end

  assign beat_wdata = wr ? steered : '0;

  always_comb begin
    if (narrow)
      assembled = word ? {hold, in_byte} : {{(DW-8){1'b0}}, in_byte};
    else
      assembled = word ? beat_rdata : {{(DW-8){1'b0}}, beat_rdata[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      gap       <= 1'b0;
      wr        <= 1'b0;
      word      <= 1'b0;
      narrow    <= 1'b0;
      low       <= 1'b0;
      burst     <= 1'b0;
      idx       <= '0;
      base      <= '0;
      wd        <= '0;
      hold      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        busy   <= 1'b1;
        gap    <= 1'b0;
        wr     <= req_write;
        word   <= req_word;
        narrow <= (cfg_port_size == 2'b01);
        low    <= cfg_lane_low;
        burst  <= req_word && (cfg_port_size == 2'b01) &&
                  (req_write ? cfg_burst_wr : cfg_burst_rd);
        idx    <= '0;
        base   <= req_addr;
        wd     <= req_wdata;
        hold   <= '0;
      end else if (done) begin
        if (is_last) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= wr ? '0 : assembled;
        end else begin
          idx  <= idx + 1'b1;
          hold <= {hold[DW-17:0], in_byte};
          gap  <= !burst;
        end
      end else if (gap) begin
        gap <= 1'b0;
      end
    end
  end

  // R4
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ($countones(beat_be) == 1 || beat_be == 4'hF));

  // R6
  single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ack && !beat_burst) |=> !beat_valid);

  // R7
  burst_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ack && beat_burst && !beat_last) |=>
      (beat_valid && beat_burst && beat_addr == $past(beat_addr) + 1'b1));

  // R9
  rsp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(beat_valid && beat_ack && beat_last));

  // R11
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ack) |=>
      (beat_valid && $stable(beat_addr) && $stable(beat_wdata) && $stable(beat_be)));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);
endmodule

// File: tb/port_splitter_bench.sv
`timescale 1ns/1ps
module port_splitter_bench;
  localparam int AW = 12;
  localparam int BW = 1 + AW + 4 + 32 + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [1:0]    cfg_port_size = 2'b00;
  logic          cfg_lane_low = 1'b0, cfg_burst_rd = 1'b0, cfg_burst_wr = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          beat_valid, beat_write, beat_burst, beat_last;
  logic [AW-1:0] beat_addr;
  logic [31:0]   beat_wdata;
  logic [3:0]    beat_be;
  logic          beat_ack = 1'b0;
  logic [31:0]   beat_rdata = '0;

  port_splitter #(.AW(AW)) u_port_splitter (
    .clk(clk), .rst_n(rst_n),
    .cfg_port_size(cfg_port_size), .cfg_lane_low(cfg_lane_low),
    .cfg_burst_rd(cfg_burst_rd), .cfg_burst_wr(cfg_burst_wr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .beat_valid(beat_valid), .beat_write(beat_write), .beat_addr(beat_addr),
    .beat_wdata(beat_wdata), .beat_be(beat_be), .beat_burst(beat_burst),
    .beat_last(beat_last), .beat_ack(beat_ack), .beat_rdata(beat_rdata)
  );

  int total = 0, bad = 0;
  int wcnt = 0;
  string cur = "R1";
  logic [BW-1:0] beat_q[$];
  logic [31:0]   rsp_q[$];
  logic prev_single = 1'b0, prev_chain = 1'b0;

  function automatic logic [31:0] mem_rd(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA1, a[7:0] ^ 8'hB2, a[7:0] ^ 8'hC3, a[7:0] ^ 8'hD4};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic word, input logic [AW-1:0] a,
                       input logic [31:0] w, input logic [1:0] ps, input logic lo,
                       input logic brd, input logic bwr, input string tag);
    logic narrow, burst;
    int nb;
    logic [31:0] res, m;
    logic [AW-1:0] ba;
    logic [7:0] ob, rb;
    logic [3:0] be;
    logic [31:0] wdv;
    narrow = (ps == 2'b01);
    nb     = (word && narrow) ? 4 : 1;
    burst  = word && narrow && (wr ? bwr : brd);
    res    = '0;
    for (int i = 0; i < nb; i++) begin
      ba = a + AW'(i);
      ob = word ? w[31 - 8*i -: 8] : w[7:0];
      if (!narrow) begin
        wdv = word ? w : {24'b0, w[7:0]};
        be  = word ? 4'hF : 4'h1;
      end else if (lo) begin
        wdv = {24'b0, ob};
        be  = 4'h1;
      end else begin
        wdv = {ob, 24'b0};
        be  = 4'h8;
      end
      if (!wr) wdv = '0;
      beat_q.push_back({wr, ba, be, wdv, burst, (!burst || i == nb - 1)});
      m  = mem_rd(ba);
      rb = lo ? m[7:0] : m[31:24];
      if (narrow) res = word ? {res[23:0], rb} : {24'b0, rb};
      else        res = word ? m : {24'b0, m[7:0]};
    end
    rsp_q.push_back(wr ? 32'h0 : res);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur           = tag;
    cfg_port_size = ps;
    cfg_lane_low  = lo;
    cfg_burst_rd  = brd;
    cfg_burst_wr  = bwr;
    req_valid     = 1'b1;
    req_write     = wr;
    req_word      = word;
    req_addr      = a;
    req_wdata     = w;
    @(negedge clk);
    req_valid     = 1'b0;
    // R11: configuration scrambled after acceptance
    cfg_port_size = ~ps;
    cfg_lane_low  = ~lo;
    cfg_burst_rd  = ~brd;
    cfg_burst_wr  = ~bwr;
    req_wdata     = ~w;
    while (rsp_q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    logic [BW-1:0] e;
    logic [31:0] r;
    wcnt++;
    if (!rst_n) begin
      beat_ack = 1'b0;
    end else begin
      if (prev_single) chk(!beat_valid, {"R6 ", cur}, 64'(beat_valid), 64'd0);
      if (prev_chain)  chk(beat_valid,  {"R7 ", cur}, 64'(beat_valid), 64'd1);
      prev_single = 1'b0;
      prev_chain  = 1'b0;
      if (beat_valid) chk(!req_ready, "R11 ready", 64'(req_ready), 64'd0);
      if (beat_valid && (wcnt % 3 != 1)) begin
        beat_ack   = 1'b1;
        beat_rdata = mem_rd(beat_addr);
        if (beat_q.size() == 0) begin
          chk(1'b0, {"beat ", cur}, 64'(beat_addr), 64'd0);
        end else begin
          e = beat_q.pop_front();
          chk({beat_write, beat_addr, beat_be, beat_wdata, beat_burst, beat_last} == e,
              {"beat ", cur},
              64'({beat_write, beat_addr, beat_be, beat_wdata, beat_burst, beat_last}), 64'(e));
        end
        prev_single = !beat_burst;
        prev_chain  = beat_burst && !beat_last;
      end else begin
        beat_ack = 1'b0;
      end
      if (rsp_valid) begin
        if (rsp_q.size() == 0) begin
          chk(1'b0, {"R9 rsp ", cur}, 64'(rsp_rdata), 64'd0);
        end else begin
          r = rsp_q.pop_front();
          chk(rsp_rdata == r, {"R9 rsp ", cur}, 64'(rsp_rdata), 64'(r));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !beat_valid && !rsp_valid, "R1 reset",
        64'({req_ready, beat_valid, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !beat_valid && !rsp_valid, "R1 after release",
        64'({req_ready, beat_valid, rsp_valid}), 64'b100);

    issue(1, 1, 12'h100, 32'h11223344, 2'b00, 0, 0, 0, "R2 wide write");
    issue(0, 1, 12'h104, 32'h0,        2'b00, 1, 0, 0, "R2 wide read");
    issue(0, 1, 12'h108, 32'h0,        2'b00, 0, 1, 1, "R2 bursts ignored");
    issue(0, 1, 12'h20C, 32'h0,        2'b10, 0, 1, 1, "R3 code 10 read");
    issue(1, 1, 12'h210, 32'hCAFEF00D, 2'b11, 1, 1, 1, "R3 code 11 write");
    issue(1, 1, 12'h300, 32'hA1B2C3D4, 2'b01, 0, 1, 0, "R5 R6 R8 split write top lane");
    issue(1, 1, 12'h310, 32'h55AA6699, 2'b01, 1, 0, 1, "R4 R7 R8 burst write low lane");
    issue(0, 1, 12'h320, 32'h0,        2'b01, 0, 1, 0, "R7 R8 R9 burst read top lane");
    issue(0, 1, 12'h330, 32'h0,        2'b01, 1, 0, 1, "R4 R6 R9 split read low lane");
    issue(1, 0, 12'h340, 32'h000000E7, 2'b01, 0, 1, 1, "R10 byte write top lane");
    issue(0, 0, 12'h341, 32'h0,        2'b01, 1, 1, 1, "R10 byte read low lane");
    issue(1, 0, 12'h342, 32'hFFFFFF3C, 2'b00, 0, 1, 1, "R10 byte write wide port");
    issue(0, 0, 12'h343, 32'h0,        2'b00, 1, 1, 1, "R10 byte read wide port");
    issue(0, 1, 12'hFFE, 32'h0,        2'b01, 0, 1, 1, "R5 address wrap burst read");
    issue(1, 1, 12'hFFD, 32'h89ABCDEF, 2'b01, 1, 0, 0, "R5 address wrap split write");

    repeat (4) @(negedge clk);
    chk(beat_q.size() == 0, "R9 leftover beats", 64'(beat_q.size()), 64'd0);
    chk(req_ready && !beat_valid, "R11 idle at end", 64'({req_ready, beat_valid}), 64'b10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule